// File: doc/BRIEF.md
# Two-Phase Noise Shift Register with Combined-Waveform Writeback

This block holds the pseudo-random noise state of a sound oscillator. It is a 23-bit linear feedback shift register. Its feedback is bit 22 XOR bit 17, and the result enters bit 0. A shift does not happen in one step. It runs as two sequenced phases, advanced only on cycles where the system enable is high. In the latch phase, each register bit is frozen in a per-bit latch and the register bit itself is left floating. In the transfer phase, each latched bit moves one position up.

A shift starts on a rising edge of accumulator bit 19. A shift is also started by holding the test control high. A long test hold keeps the register parked in the latch phase, and the transfer happens once test is released. Reset loads all ones.

Eight register bits are tapped to form the noise output. They form waveform output bits 11 down to 4. When noise is mixed with another waveform, the combined output drives back onto those eight bits. In normal cycles and in the transfer phase, a low combined bit clears its register bit. In the latch phase, the floating bits take the combined value. Bits that nothing drives are set to one after a configurable number of latch-phase cycles.

Top module: `noise_lfsr_top`

## Requirements
- R1: While `rst_n` is low, the register reads all ones, both phase flags are low and `noise_o` is 8'hFF.
- R2: An enabled cycle that samples `acc_b19_i` high after it was sampled low makes the next enabled cycle a latch phase (`ph1_o`). The enabled cycle after that is a transfer phase (`ph2_o`). A level that stays high starts no further shift, and a transfer phase never lasts two enabled cycles.
- R3: Each enabled cycle that samples `test_i` high makes the next cycle a latch phase. The first enabled cycle after `test_i` is sampled low again is a transfer phase.
- R4: At the start of a latch phase, the per-bit latch takes the register value. The latch holds that value for the whole latch phase. Register bits that nothing drives keep their value until the drift limit is reached.
- R5: In a transfer phase, the register becomes the latch shifted up one place, with bit 0 set to latch bit 22 XOR latch bit 17.
- R6: Outside the latch phase, while `combo_en_i` is high, each tapped register bit is ANDed with its `combo_i` bit as the register updates. While `combo_en_i` is low, `combo_i` has no effect.
- R7: In a latch phase with `combo_en_i` high, each tapped register bit takes the value of its `combo_i` bit.
- R8: In the FLOAT_CYC-th consecutive enabled latch-phase cycle (default 4), and in every later one, every register bit that `combo_i` does not drive becomes 1.
- R9: `noise_o[7:0]` equals register bits {20,18,14,11,9,5,2,0}, most significant first, so `noise_o[7]` is bit 20. `combo_i[k]` pairs with `noise_o[k]`.
- R10: On a cycle with `clk_en` low, neither the register, the latch, the phase nor the bit-19 history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, loads all ones |
| clk_en | input | 1 | System enable; state advances only when high |
| acc_b19_i | input | 1 | Accumulator bit 19 |
| test_i | input | 1 | Test control bit |
| combo_en_i | input | 1 | Noise is combined with another waveform |
| combo_i | input | 8 | Combined waveform output bits 11..4 |
| noise_o | output | 8 | Noise waveform bits 11..4 |
| sr_o | output | 23 | Shift register contents |
| ph1_o | output | 1 | Latch phase active |
| ph2_o | output | 1 | Transfer phase active |

## Verification
A wrong latch value stays hidden during the latch phase. It shows up in `sr_o` in the cycle right after the transfer phase, and in `noise_o` if a tapped bit is affected. A wrong phase sequence shows up at once on the phase flags. From that cycle on, every later shift differs from the reference. A missed or extra writeback changes `sr_o` in the cycle after the enabled edge. The LFSR then carries that error through every following shift, so the bench compares the full register every cycle against its own model of the sequence.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

  localparam int NOUT = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LATCH = 2'd1,
    PH_XFER  = 2'd2
  } phase_e;

  // register bit feeding noise output bit k (k = 0 is least significant)
  function automatic int tap_pos(input int k);
    case (k)
      0: return 0;
      1: return 2;
      2: return 5;
      3: return 9;
      4: return 11;
      5: return 14;
      6: return 18;
      default: return 20;
    endcase
  endfunction

  // phase sequencing rule
  function automatic phase_e next_phase(input phase_e cur, input logic test, input logic rise);
    if (test)                 return PH_LATCH;
    else if (cur == PH_LATCH) return PH_XFER;
    else if (rise)            return PH_LATCH;
    else                      return PH_IDLE;
  endfunction

endpackage

// File: rtl/noise_phase_seq.sv
module noise_phase_seq
  import noise_lfsr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clk_en,
  input  logic   acc_b19,
  input  logic   test,
  output phase_e phase_q,
  output logic   b19_rise
);

  logic   b19_q;
  phase_e phase_d;

  assign b19_rise = acc_b19 & ~b19_q;
  assign phase_d  = next_phase(phase_q, test, b19_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b19_q   <= 1'b0;
      phase_q <= PH_IDLE;
    end else if (clk_en) begin
      b19_q   <= acc_b19;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/noise_float_timer.sv
module noise_float_timer #(
  parameter int FLOAT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic in_latch,
  output logic drift
);

  localparam int CW = $clog2(FLOAT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FLOAT_CYC);
  localparam logic [CW-1:0] FIRE  = CW'(FLOAT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign drift = in_latch && (cnt_q >= FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clk_en) begin
      if (!in_latch)          cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/noise_shift_core.sv
module noise_shift_core
  import noise_lfsr_pkg::*;
#(
  parameter int SR_W = 23,
  parameter int FB_B = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  phase_e          phase,
  input  logic            drift,
  input  logic            combo_en,
  input  logic [NOUT-1:0] combo,
  output logic [SR_W-1:0] sr_q,
  output logic [SR_W-1:0] latch_q
);

  localparam int FB_A = SR_W - 1;

  logic [SR_W-1:0] sr_d, latch_d;
  logic [SR_W-1:0] wb_mask, drv_mask, drv_val;

  function automatic logic [SR_W-1:0] xfer(input logic [SR_W-1:0] l);
    return {l[SR_W-2:0], l[FB_A] ^ l[FB_B]};
  endfunction

  always_comb begin
    wb_mask  = '1;
    drv_mask = '0;
    drv_val  = '0;
    for (int k = 0; k < NOUT; k++) begin
      wb_mask[tap_pos(k)]  = combo_en ? combo[k] : 1'b1;
      drv_mask[tap_pos(k)] = combo_en;
      drv_val[tap_pos(k)]  = combo[k];
    end
  end

  always_comb begin
    case (phase)
      PH_LATCH: begin
        sr_d = (sr_q & ~drv_mask) | (drv_val & drv_mask);
        if (drift) sr_d = sr_d | ~drv_mask;
      end
      PH_XFER: sr_d = xfer(latch_q) & wb_mask;
      default: sr_d = sr_q & wb_mask;
    endcase
    latch_d = (phase == PH_LATCH) ? latch_q : sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '1;
      latch_q <= '1;
    end else if (clk_en) begin
      sr_q    <= sr_d;
      latch_q <= latch_d;
    end
  end

endmodule

// File: rtl/noise_lfsr_top.sv
module noise_lfsr_top
  import noise_lfsr_pkg::*;
#(
  parameter int SR_W      = 23,
  parameter int FB_B      = 17,
  parameter int FLOAT_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            acc_b19_i,
  input  logic            test_i,
  input  logic            combo_en_i,
  input  logic [7:0]      combo_i,
  output logic [7:0]      noise_o,
  output logic [SR_W-1:0] sr_o,
  output logic            ph1_o,
  output logic            ph2_o
);

  phase_e          phase_q;
  logic            b19_rise;
  logic            drift;
  logic [SR_W-1:0] sr_q, latch_q;

  noise_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .acc_b19  (acc_b19_i),
    .test     (test_i),
    .phase_q  (phase_q),
    .b19_rise (b19_rise)
  );

  noise_float_timer #(.FLOAT_CYC(FLOAT_CYC)) u_float (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .in_latch (phase_q == PH_LATCH),
    .drift    (drift)
  );

  noise_shift_core #(.SR_W(SR_W), .FB_B(FB_B)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .phase    (phase_q),
    .drift    (drift),
    .combo_en (combo_en_i),
    .combo    (combo_i),
    .sr_q     (sr_q),
    .latch_q  (latch_q)
  );

  for (genvar k = 0; k < NOUT; k++) begin : g_tap
    assign noise_o[k] = sr_q[tap_pos(k)];
  end

  assign sr_o  = sr_q;
  assign ph1_o = (phase_q == PH_LATCH);
  assign ph2_o = (phase_q == PH_XFER);

endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk #(
  parameter int SR_W = 23,
  parameter int FB_B = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk_en,
  input logic            test_i,
  input logic            combo_en_i,
  input logic [7:0]      combo_i,
  input logic [7:0]      noise_o,
  input logic [SR_W-1:0] sr_o,
  input logic [SR_W-1:0] latch_q,
  input logic            ph1_o,
  input logic            ph2_o
);

  a_r2_xfer_single: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && ph2_o |=> !ph2_o);

  a_r3_test_holds_latch: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && test_i |=> ph1_o);

  a_r4_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && ph1_o |=> $stable(latch_q));

  a_r5_xfer_shift: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && ph2_o && !combo_en_i |=>
      sr_o == {$past(latch_q[SR_W-2:0]), $past(latch_q[SR_W-1] ^ latch_q[FB_B])});

  a_r6_writeback_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && combo_en_i && !ph1_o |=> (noise_o & ~$past(combo_i)) == 8'h00);

  a_r7_float_driven: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && combo_en_i && ph1_o |=> noise_o == $past(combo_i));

  a_r10_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(sr_o) && $stable(latch_q));

endmodule

bind noise_lfsr_top noise_lfsr_chk #(.SR_W(SR_W), .FB_B(FB_B)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en     (clk_en),
  .test_i     (test_i),
  .combo_en_i (combo_en_i),
  .combo_i    (combo_i),
  .noise_o    (noise_o),
  .sr_o       (sr_o),
  .latch_q    (latch_q),
  .ph1_o      (ph1_o),
  .ph2_o      (ph2_o)
);

// File: tb/test_noise_lfsr_top.sv
module test_noise_lfsr_top;

  localparam int W  = 23;
  localparam int FC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0, acc_b19_i = 1'b0, test_i = 1'b0, combo_en_i = 1'b0;
  logic [7:0] combo_i = 8'h00;
  logic [7:0] noise_o;
  logic [W-1:0] sr_o;
  logic ph1_o, ph2_o;

  always #2 clk = ~clk;

  noise_lfsr_top i_noise_lfsr_top (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .acc_b19_i(acc_b19_i),
    .test_i(test_i), .combo_en_i(combo_en_i), .combo_i(combo_i),
    .noise_o(noise_o), .sr_o(sr_o), .ph1_o(ph1_o), .ph2_o(ph2_o)
  );

  typedef struct {
    logic [W-1:0] sr;
    int           ph;
    string        tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int tapv[8] = '{0, 2, 5, 9, 11, 14, 18, 20};

  // reference state
  logic [W-1:0] m_sr = '1, m_latch = '1;
  int m_ph = 0, m_cnt = 0;
  bit m_prev = 0;

  function automatic logic [7:0] taps_of(input logic [W-1:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = v[tapv[k]];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit ce, input bit b19, input bit tst, input bit cen,
                       input logic [7:0] cb, input string tag);
    logic [W-1:0] nsr;
    bit rise;
    item_t it;
    @(negedge clk);
    clk_en = ce; acc_b19_i = b19; test_i = tst; combo_en_i = cen; combo_i = cb;
    if (ce) begin
      rise = b19 && !m_prev;
      nsr = m_sr;
      if (m_ph == 1) begin
        if (m_cnt >= FC - 1) nsr = '1;
        if (cen) for (int k = 0; k < 8; k++) nsr[tapv[k]] = cb[k];
      end else begin
        if (m_ph == 2) nsr = {m_latch[W-2:0], m_latch[22] ^ m_latch[17]};
        if (cen) for (int k = 0; k < 8; k++) nsr[tapv[k]] = nsr[tapv[k]] & cb[k];
      end
      m_cnt = (m_ph == 1) ? ((m_cnt < FC) ? m_cnt + 1 : m_cnt) : 0;
      if (m_ph != 1) m_latch = nsr;
      m_ph = tst ? 1 : (m_ph == 1) ? 2 : rise ? 1 : 0;
      m_prev = b19;
      m_sr = nsr;
    end
    it.sr = m_sr; it.ph = m_ph; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares each expected item one step after the edge it belongs to
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({it.tag, " register"}, 32'(sr_o), 32'(it.sr));
      check({it.tag, " phase"}, {30'd0, ph2_o, ph1_o},
            {30'd0, it.ph == 2, it.ph == 1});
      check("R9 noise taps", 32'(noise_o), 32'(taps_of(it.sr)));
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset register", 32'(sr_o), 32'h7FFFFF);
    check("R1 reset phase", {30'd0, ph2_o, ph1_o}, 32'd0);
    check("R1 reset noise", 32'(noise_o), 32'hFF);
    @(negedge clk); rst_n = 1'b1;

    repeat (3) drive(1, 0, 0, 0, 8'h00, "R6 idle no combo");
    // single bit-19 pulse, level held high
    repeat (3) drive(1, 1, 0, 0, 8'h00, "R2");
    repeat (2) drive(1, 0, 0, 0, 8'h00, "R5");
    for (int i = 0; i < 24; i++) begin
      drive(1, 1, 0, 0, 8'h00, "R5 shift");
      drive(1, 0, 0, 0, 8'h00, "R5 shift");
      drive(1, 0, 0, 0, 8'h00, "R5 shift");
    end
    // long test hold: latch held, drift after FC cycles
    repeat (3) drive(1, 0, 1, 0, 8'h00, "R4 hold");
    repeat (5) drive(1, 0, 1, 0, 8'h00, "R8 drift");
    repeat (3) drive(1, 0, 0, 0, 8'h00, "R3 release");
    for (int i = 0; i < 10; i++) begin
      drive(1, 1, 0, 0, 8'h00, "R5 shift");
      drive(1, 0, 0, 0, 8'h00, "R5 shift");
    end
    // writeback in normal cycles
    drive(1, 0, 0, 1, 8'hA5, "R6 writeback");
    drive(1, 0, 0, 1, 8'hFF, "R6 writeback");
    drive(1, 0, 0, 0, 8'h00, "R6 combo off");
    // combined drive during latch, writeback in transfer
    drive(1, 1, 0, 1, 8'h3C, "R6 writeback");
    drive(1, 0, 0, 1, 8'h3C, "R7 float driven");
    drive(1, 0, 0, 1, 8'hC3, "R6 xfer writeback");
    drive(1, 0, 0, 0, 8'h00, "R5");
    // test hold with combined drive
    repeat (6) drive(1, 0, 1, 1, 8'h5A, "R7 R8 hold");
    drive(1, 0, 0, 1, 8'hF0, "R3 release");
    drive(1, 0, 0, 0, 8'h00, "R3 release");
    // one-cycle test pulse
    drive(1, 0, 1, 0, 8'h00, "R3 short");
    repeat (3) drive(1, 0, 0, 0, 8'h00, "R3 short");
    // enable low: nothing moves, history kept
    repeat (4) drive(0, 1, 1, 1, 8'h00, "R10 gated");
    drive(1, 1, 0, 0, 8'h00, "R10 resume");
    repeat (3) drive(1, 1, 0, 0, 8'h00, "R2 level");
    drive(1, 0, 0, 0, 8'h00, "R2 level");
    // enable low in mid latch phase
    drive(1, 1, 0, 0, 8'h00, "R2");
    drive(0, 0, 0, 0, 8'h00, "R10 gated latch");
    drive(0, 0, 0, 0, 8'h00, "R10 gated latch");
    repeat (3) drive(1, 0, 0, 0, 8'h00, "R5");
    for (int i = 0; i < 20; i++) begin
      drive(1, 1, 0, i[0], 8'(8'hE7 ^ i), "R6 mixed");
      drive(1, 0, 0, 0, 8'h00, "R5 mixed");
      drive(1, 0, 0, 0, 8'h00, "R5 mixed");
    end
    drive(1, 0, 0, 0, 8'h00, "R5 tail");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule